// File: doc/BRIEF.md
# Dual-Slope Converter Sequencer

This block supplies the timing and control for an integrating analog-to-digital converter of the dual-slope kind. The integrator, its input switch and the zero-crossing comparator sit outside it. A conversion starts from idle when `start` is seen. The integrator is first held in reset for a programmable number of clocks. The switch then connects the analog input for a run-up of fixed length, and that length is measured by the block's own counter. When run-up ends, the counter clears, the input polarity bit is captured, and the switch moves to a reference of the opposite polarity. The counter then runs until the comparator reports that the integrator is back at zero.

That second count is the conversion result. It scales with the input and does not depend on the clock rate or on the integrator's component values. The block pulses `done` for one clock and holds the result and its sign until the next successful conversion. If zero is not reached within twice the run-up length, the block raises `overrange` and returns to idle without pulsing `done`.

Top module: `dsadc_seq`

## Requirements
- R1: After reset, `busy`, `done`, `overrange`, `intReset` and `selInput` are 0, and `result` is 0.
- R2: When `start` is sampled high in idle, `intReset` is high for exactly max(`azCycles`,1) clocks starting the next clock, with `selInput` low.
- R3: Immediately after the reset window, `selInput` is high for exactly RUNUP_LEN clocks, with `intReset` low.
- R4: `signIn` (1 = negative input) is captured on the last run-up clock. During run-down, `selRefNeg` equals the inverse of the captured bit (1 selects the negative reference). `resultSign` reports the captured bit together with the result.
- R5: The run-down count starts at 0 on the first run-down clock and rises by one each clock. `result` is the count on the first run-down clock on which `cmpZero` is high.
- R6: `done` is high for exactly one clock, on the clock after zero was detected. `busy` is high from the clock after `start` through that clock, for max(`azCycles`,1)+RUNUP_LEN+`result`+2 clocks.
- R7: `result` and `resultSign` change only together with `done`. They keep their value through idle and through a conversion that ends in overrange.
- R8: If `cmpZero` stays low up to and including count 2*RUNUP_LEN, `overrange` is set on that clock, the block returns to idle and `done` does not pulse. `overrange` clears on the next accepted `start`.
- R9: If `cmpZero` first rises exactly at count 2*RUNUP_LEN, the conversion completes normally with `result` = 2*RUNUP_LEN and no overrange.
- R10: `start` has no effect while `busy` is high.
- R11: `cmpZero` is ignored outside run-down, so a comparator that is already high during reset or run-up does not cut the conversion short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion when idle |
| azCycles | input | AZ_W | Length of the integrator reset window, 0 acts as 1 |
| signIn | input | 1 | Input polarity, 1 = negative |
| cmpZero | input | 1 | Comparator: integrator has reached or crossed zero |
| intReset | output | 1 | Hold integrator at zero |
| selInput | output | 1 | Switch connects the analog input |
| selRefNeg | output | 1 | During run-down, 1 selects the negative reference |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-clock completion pulse |
| overrange | output | 1 | Last conversion timed out |
| result | output | $clog2(2*RUNUP_LEN+1) | Run-down count |
| resultSign | output | 1 | Polarity that goes with result |

## Verification
Two events can fall on the same clock: the zero detection and the run-down timeout, when `cmpZero` first rises at count 2*RUNUP_LEN. The bench models the integrator as a signed accumulator with a reference of 5 and a run-up of 16. An input magnitude of exactly 10 therefore reaches zero on the timeout count, and the bench expects a normal result of 32 with no overrange. A magnitude of 11 must give overrange, no `done` pulse and an unchanged result.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AZ,
    ST_RUNUP,
    ST_RUNDOWN,
    ST_DONE
  } seqState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic capSign;
    logic capResult;
    logic setOvr;
    logic clrOvr;
  } dpStrobe_t;

endpackage

// File: rtl/dsadc_dp.sv
module dsadc_dp
  import dsadc_pkg::*;
#(
  parameter int RUNUP_LEN = 16,
  parameter int AZ_W      = 3,
  parameter int RES_W     = 6,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [AZ_W-1:0]  azCycles,
  input  logic             signIn,
  output logic             azLast,
  output logic             runupLast,
  output logic             tmoHit,
  output logic             signHeld,
  output logic [RES_W-1:0] result,
  output logic             resultSign,
  output logic             overrange
);

  localparam int TMO = 2 * RUNUP_LEN;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cntNext;

  assign cntNext   = {1'b0, cnt} + 1'b1;
  assign azLast    = cntNext >= (CNT_W+1)'(azCycles);
  assign runupLast = cnt == CNT_W'(RUNUP_LEN - 1);
  assign tmoHit    = cnt == CNT_W'(TMO);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.cntClr) begin
      cnt <= '0;
    end else if (strobe.cntInc) begin
      cnt <= cntNext[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      signHeld <= 1'b0;
    end else if (strobe.capSign) begin
      signHeld <= signIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result     <= '0;
      resultSign <= 1'b0;
    end else if (strobe.capResult) begin
      result     <= cnt[RES_W-1:0];
      resultSign <= signHeld;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrange <= 1'b0;
    end else if (strobe.setOvr) begin
      overrange <= 1'b1;
    end else if (strobe.clrOvr) begin
      overrange <= 1'b0;
    end
  end

endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      cmpZero,
  input  logic      azLast,
  input  logic      runupLast,
  input  logic      tmoHit,
  input  logic      signHeld,
  output dpStrobe_t strobe,
  output logic      intReset,
  output logic      selInput,
  output logic      selRefNeg,
  output logic      busy,
  output logic      done
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stateNext     = ST_AZ;
          strobe.cntClr = 1'b1;
          strobe.clrOvr = 1'b1;
        end
      end
      ST_AZ: begin
        if (azLast) begin
          stateNext     = ST_RUNUP;
          strobe.cntClr = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_RUNUP: begin
        if (runupLast) begin
          stateNext      = ST_RUNDOWN;
          strobe.cntClr  = 1'b1;
          strobe.capSign = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_RUNDOWN: begin
        if (cmpZero) begin
          stateNext        = ST_DONE;
          strobe.capResult = 1'b1;
        end else if (tmoHit) begin
          stateNext     = ST_IDLE;
          strobe.setOvr = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_DONE: begin
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign intReset  = state == ST_AZ;
  assign selInput  = state == ST_RUNUP;
  assign selRefNeg = (state == ST_RUNDOWN) && !signHeld;
  assign busy      = state != ST_IDLE;
  assign done      = state == ST_DONE;

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq #(
  parameter int RUNUP_LEN = 16,
  parameter int AZ_W      = 3,
  localparam int TMO      = 2 * RUNUP_LEN,
  localparam int RES_W    = $clog2(TMO + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [AZ_W-1:0]  azCycles,
  input  logic             signIn,
  input  logic             cmpZero,
  output logic             intReset,
  output logic             selInput,
  output logic             selRefNeg,
  output logic             busy,
  output logic             done,
  output logic             overrange,
  output logic [RES_W-1:0] result,
  output logic             resultSign
);

  localparam int CNT_W = (RES_W > AZ_W) ? RES_W : AZ_W;

  dsadc_pkg::dpStrobe_t strobe;
  logic azLast, runupLast, tmoHit, signHeld;

  dsadc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .cmpZero   (cmpZero),
    .azLast    (azLast),
    .runupLast (runupLast),
    .tmoHit    (tmoHit),
    .signHeld  (signHeld),
    .strobe    (strobe),
    .intReset  (intReset),
    .selInput  (selInput),
    .selRefNeg (selRefNeg),
    .busy      (busy),
    .done      (done)
  );

  dsadc_dp #(
    .RUNUP_LEN (RUNUP_LEN),
    .AZ_W      (AZ_W),
    .RES_W     (RES_W),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .azCycles   (azCycles),
    .signIn     (signIn),
    .azLast     (azLast),
    .runupLast  (runupLast),
    .tmoHit     (tmoHit),
    .signHeld   (signHeld),
    .result     (result),
    .resultSign (resultSign),
    .overrange  (overrange)
  );

endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int RUNUP_LEN = 16,
  localparam int RES_W    = $clog2(2 * RUNUP_LEN + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             signIn,
  input logic             intReset,
  input logic             selInput,
  input logic             selRefNeg,
  input logic             busy,
  input logic             done,
  input logic             overrange,
  input logic [RES_W-1:0] result,
  input logic             resultSign
);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  az_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReset |-> (busy && !selInput && !done));

  // R3
  runup_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    selInput |-> (busy && !intReset));

  // R4
  ref_pol_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selInput) |-> (selRefNeg == !$past(signIn)));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(result) || !$stable(resultSign)) |-> done);

  // R8
  ovr_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrange) |-> (!busy && !done));

  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intReset) |-> !$past(busy));

endmodule

bind dsadc_seq dsadc_seq_chk #(.RUNUP_LEN(RUNUP_LEN)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .signIn     (signIn),
  .intReset   (intReset),
  .selInput   (selInput),
  .selRefNeg  (selRefNeg),
  .busy       (busy),
  .done       (done),
  .overrange  (overrange),
  .result     (result),
  .resultSign (resultSign)
);

// File: tb/dsadc_seq_bench.sv
`timescale 1ns/1ps
module dsadc_seq_bench;

  localparam int RUNUP_LEN = 16;
  localparam int AZ_W      = 3;
  localparam int TMO       = 2 * RUNUP_LEN;
  localparam int RES_W     = $clog2(TMO + 1);
  localparam int VREF      = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AZ_W-1:0] azCycles = '0;
  logic signIn, cmpZero;
  logic intReset, selInput, selRefNeg, busy, done, overrange, resultSign;
  logic [RES_W-1:0] result;

  int vin = 0;
  int integ = 0;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  // integrator and comparator model
  assign signIn  = vin < 0;
  assign cmpZero = (vin < 0) ? (integ >= 0) : (integ <= 0);

  always @(posedge clk) begin
    if (intReset)            integ <= 0;
    else if (selInput)       integ <= integ + vin;
    else if (busy && !done)  integ <= integ + (selRefNeg ? -VREF : VREF);
  end

  dsadc_seq #(.RUNUP_LEN(RUNUP_LEN), .AZ_W(AZ_W)) u_dsadc_seq (
    .clk(clk), .rstN(rstN), .start(start), .azCycles(azCycles),
    .signIn(signIn), .cmpZero(cmpZero), .intReset(intReset),
    .selInput(selInput), .selRefNeg(selRefNeg), .busy(busy), .done(done),
    .overrange(overrange), .result(result), .resultSign(resultSign)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runConv(input int v, input int az, input bit midStart);
    int a, expRes, azEff, nBusy, nAz, nUp, nDone, gotRes, gotSign, refBad;
    int prevRes, prevSign;
    bit expOvr;
    a       = (v < 0) ? -v : v;
    expRes  = (RUNUP_LEN * a + VREF - 1) / VREF;
    expOvr  = expRes > TMO;
    azEff   = (az == 0) ? 1 : az;
    prevRes = int'(result);
    prevSign = int'(resultSign);
    nBusy = 0; nAz = 0; nUp = 0; nDone = 0; gotRes = -1; gotSign = -1; refBad = 0;
    vin = v;
    azCycles = AZ_W'(az);
    @(negedge clk) start = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      start = midStart && (i == 6);
      if (!busy) break;
      nBusy++;
      if (intReset) nAz++;
      if (selInput) nUp++;
      if (done) begin
        nDone++;
        gotRes = int'(result);
        gotSign = int'(resultSign);
      end
      if (!intReset && !selInput && !done && (selRefNeg != (v >= 0))) refBad++;
    end
    chk(nAz == azEff, "R2 reset window length", nAz, azEff);
    chk(nUp == RUNUP_LEN, "R3 run-up length", nUp, RUNUP_LEN);
    chk(refBad == 0, "R4 reference polarity", refBad, 0);
    if (!expOvr) begin
      // R5 R9 R11
      chk(gotRes == expRes, "R5 result", gotRes, expRes);
      chk(gotSign == int'(v < 0), "R4 result sign", gotSign, int'(v < 0));
      chk(nDone == 1, "R6 done pulse count", nDone, 1);
      chk(nBusy == azEff + RUNUP_LEN + expRes + 2, "R6 busy length",
          nBusy, azEff + RUNUP_LEN + expRes + 2);
      chk(overrange == 1'b0, "R9 no overrange", int'(overrange), 0);
    end else begin
      chk(overrange == 1'b1, "R8 overrange flag", int'(overrange), 1);
      chk(nDone == 0, "R8 no done", nDone, 0);
      chk(nBusy == azEff + RUNUP_LEN + TMO + 1, "R8 busy length",
          nBusy, azEff + RUNUP_LEN + TMO + 1);
      chk(int'(result) == prevRes, "R7 result kept on overrange", int'(result), prevRes);
      chk(int'(resultSign) == prevSign, "R7 sign kept on overrange", int'(resultSign), prevSign);
      gotRes = prevRes;
    end
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 stray start ignored", int'(busy), 0);
    chk(int'(result) == gotRes, "R7 result held in idle", int'(result), gotRes);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(busy == 1'b0 && done == 1'b0 && overrange == 1'b0, "R1 idle flags",
        int'({busy, done, overrange}), 0);
    chk(intReset == 1'b0 && selInput == 1'b0, "R1 switch outputs",
        int'({intReset, selInput}), 0);
    chk(result == '0, "R1 result", int'(result), 0);
    // sweep covers R9 (|v|=10 hits timeout count) and R11 (v=0, cmpZero always high)
    for (int v = -12; v <= 12; v++) begin
      runConv(v, (v + 12) % 5, (v % 4) == 0);
    end
    runConv(7, 7, 1'b1);
    runConv(10, 0, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule